// File: doc/BRIEF.md
# Startup Cache Class-Clear Sequencer

This block puts a set-associative cache into a known state after reset. When it is started it walks the congruence classes of the cache one at a time. For each class it drives a line-aligned address and a one-cycle strobe into the cache's class-invalidate port, and that port clears every way of the addressed class. Until the first complete walk has finished, the arrays hold arbitrary tags, data and status bits. For that reason the enable output that lets the cache serve accesses stays low until such a walk has run.

A down-counter loaded with the class count sets the length of the walk. An address register starts at zero and moves forward by one line size per step. A second mode clears only the single class that contains a given address. That mode suits targeted clean-up, but it never counts as initialisation. A software enable request takes effect only when a full walk has completed.

Top module: `cache_sweep_ctrl`

## Requirements
- R1: While reset is held and in the cycle after it is released, `busy_o`, `inv_strobe_o` and `cache_en_o` are all 0, whatever `sw_enable_i` is.
- R2: A `start_i` seen at a rising edge while `busy_o` is 0 is accepted. In the next cycle `busy_o` is 1 and `inv_strobe_o` is 0, which is the single setup cycle.
- R3: With `full_mode_i`=1 at acceptance, `inv_strobe_o` is high for exactly NUM_CLASSES consecutive cycles after the setup cycle. In strobe cycle k (counting from 0) `inv_addr_o` equals k*LINE_BYTES, whatever `start_addr_i` is.
- R4: With `full_mode_i`=0 at acceptance, exactly one strobe cycle follows the setup cycle. Its address is `start_addr_i` with the low log2(LINE_BYTES) bits cleared.
- R5: `busy_o` stays 1 from the setup cycle through the last strobe cycle and is 0 in the cycle that follows. A walk of n classes therefore keeps `busy_o` high for n+1 cycles.
- R6: While `busy_o` is 1, `start_i`, `full_mode_i` and `start_addr_i` have no effect. The walk in progress keeps its addresses and length, and no further walk begins after it.
- R7: `cache_en_o` = sweep_done AND `sw_enable_i`. The internal flag sweep_done becomes 1 in the same cycle that `busy_o` falls at the end of a full-mode walk, and it stays 1 until reset.
- R8: A single-class walk (R4) never sets sweep_done.
- R9: Before the first full-mode walk has completed, `sw_enable_i`=1 leaves `cache_en_o` at 0.
- R10: `inv_strobe_o` is only ever 1 while `busy_o` is 1, and every strobed address is line aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a walk |
| full_mode_i | input | 1 | 1: clear all classes from address 0; 0: clear one class |
| start_addr_i | input | ADDR_W | Address that selects the class in single-class mode |
| sw_enable_i | input | 1 | Software request to enable the cache |
| inv_addr_o | output | ADDR_W | Line-aligned address of the class being invalidated |
| inv_strobe_o | output | 1 | One-cycle invalidate pulse for each class |
| busy_o | output | 1 | Walk in progress, including the setup cycle |
| cache_en_o | output | 1 | Cache enable, gated by completion of a full walk |

## Verification
The first directed walk is single-class, with the software enable already high. It shows that a targeted clear leaves the cache disabled, which sets it apart from a full walk. Next comes a full walk started with a nonzero, unaligned start address while start pulses and mode changes are injected mid-walk. This walk tells an address sequence taken from zero apart from one that follows the start input, and it tells an ignored restart apart from an accepted one. Random sequences then mix both modes, random addresses, random software-enable levels and restart attempts. Each walk's strobe count and address list are compared with bench-computed values, which exposes off-by-one errors in length, stride and alignment.

// File: rtl/cs_pkg.sv
package cs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_WALK  = 2'd2
    } sweep_st_e;

    typedef struct packed {
        sweep_st_e st;
        logic      full;
        logic      done;
    } sweep_ctl_s;
endpackage

// File: rtl/cs_down_counter.sv
module cs_down_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         dec_i,
    output logic [W-1:0] cnt_o,
    output logic         last_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (dec_i && cnt_q != '0) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o  = cnt_q;
    assign last_o = (cnt_q == W'(1));
endmodule

// File: rtl/cs_line_addr.sv
module cs_line_addr #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_val_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(LINE_BYTES);

    logic [ADDR_W-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (load_i)      addr_d = load_val_i;
        else if (step_i) addr_d = addr_q + STRIDE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign addr_o = addr_q;
endmodule

// File: rtl/cache_sweep_ctrl.sv
module cache_sweep_ctrl #(
    parameter int ADDR_W      = 32,
    parameter int NUM_CLASSES = 64,
    parameter int LINE_BYTES  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              full_mode_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              sw_enable_i,
    output logic [ADDR_W-1:0] inv_addr_o,
    output logic              inv_strobe_o,
    output logic              busy_o,
    output logic              cache_en_o
);
    import cs_pkg::*;

    localparam int CNT_W = $clog2(NUM_CLASSES + 1);
    localparam logic [ADDR_W-1:0] LINE_MASK = ADDR_W'(LINE_BYTES - 1);

    sweep_ctl_s ctl_d, ctl_q;

    logic              accept;
    logic              walking;
    logic              cnt_last;
    logic [CNT_W-1:0]  cnt_load;
    logic [CNT_W-1:0]  cnt_val;
    logic [ADDR_W-1:0] addr_load;

    assign accept    = (ctl_q.st == ST_IDLE) && start_i;
    assign walking   = (ctl_q.st == ST_WALK);
    assign cnt_load  = full_mode_i ? CNT_W'(NUM_CLASSES) : CNT_W'(1);
    assign addr_load = full_mode_i ? '0 : (start_addr_i & ~LINE_MASK);

    cs_down_counter #(.W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (accept),
        .load_val_i (cnt_load),
        .dec_i      (walking),
        .cnt_o      (cnt_val),
        .last_o     (cnt_last)
    );

    cs_line_addr #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (accept),
        .load_val_i (addr_load),
        .step_i     (walking),
        .addr_o     (inv_addr_o)
    );

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.st   = ST_SETUP;
                    ctl_d.full = full_mode_i;
                end
            end
            ST_SETUP: begin
                ctl_d.st = ST_WALK;
            end
            ST_WALK: begin
                if (cnt_last || cnt_val == '0) begin
                    ctl_d.st = ST_IDLE;
                    if (ctl_q.full) ctl_d.done = 1'b1;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st   <= ST_IDLE;
            ctl_q.full <= 1'b0;
            ctl_q.done <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign inv_strobe_o = walking;
    assign busy_o       = (ctl_q.st != ST_IDLE);
    assign cache_en_o   = ctl_q.done && sw_enable_i;
endmodule

// File: rtl/cache_sweep_ctrl_chk.sv
module cache_sweep_ctrl_chk #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              sw_enable_i,
    input logic [ADDR_W-1:0] inv_addr_o,
    input logic              inv_strobe_o,
    input logic              busy_o,
    input logic              cache_en_o
);
    localparam logic [ADDR_W-1:0] LMASK = ADDR_W'(LINE_BYTES - 1);
    localparam logic [ADDR_W-1:0] LSTEP = ADDR_W'(LINE_BYTES);

    AST_STROBE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        inv_strobe_o |-> busy_o); // R10
    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        inv_strobe_o |-> ((inv_addr_o & LMASK) == '0)); // R10
    AST_ADDR_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_strobe_o && $past(inv_strobe_o)) |-> (inv_addr_o == $past(inv_addr_o) + LSTEP)); // R3
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && !inv_strobe_o)); // R2
    AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(inv_strobe_o)); // R5
    AST_EN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        cache_en_o |-> sw_enable_i); // R9
    AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cache_en_o) && sw_enable_i) |-> cache_en_o); // R7
endmodule

bind cache_sweep_ctrl cache_sweep_ctrl_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_chk (.*);

// File: tb/cache_sweep_ctrl_bench.sv
module cache_sweep_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW  = 32;
    localparam int NCL = 64;
    localparam int LB  = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          full_mode_i = 1'b0;
    logic [AW-1:0] start_addr_i = '0;
    logic          sw_enable_i = 1'b0;
    logic [AW-1:0] inv_addr_o;
    logic          inv_strobe_o, busy_o, cache_en_o;

    int unsigned total = 0;
    int unsigned bad = 0;
    bit          done_m = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cache_sweep_ctrl #(.ADDR_W(AW), .NUM_CLASSES(NCL), .LINE_BYTES(LB)) u_cache_sweep_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .full_mode_i(full_mode_i),
        .start_addr_i(start_addr_i), .sw_enable_i(sw_enable_i),
        .inv_addr_o(inv_addr_o), .inv_strobe_o(inv_strobe_o),
        .busy_o(busy_o), .cache_en_o(cache_en_o)
    );

    function automatic logic [AW-1:0] exp_addr(bit full, logic [AW-1:0] base, int k);
        if (full) return AW'(k * LB);
        return base & ~AW'(LB - 1);
    endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic run_op(bit full, logic [AW-1:0] base, bit poke);
        int n;
        n = full ? NCL : 1;
        @(negedge clk);
        start_i = 1'b1; full_mode_i = full; start_addr_i = base;
        @(negedge clk);
        start_i = 1'b0; full_mode_i = 1'($urandom); start_addr_i = $urandom;
        chk(busy_o == 1'b1, "R2 busy in setup", 64'(busy_o), 64'd1);
        chk(inv_strobe_o == 1'b0, "R2 no strobe in setup", 64'(inv_strobe_o), 64'd0);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk(inv_strobe_o == 1'b1, full ? "R3 strobe" : "R4 strobe", 64'(inv_strobe_o), 64'd1);
            chk(busy_o == 1'b1, "R5 busy during walk", 64'(busy_o), 64'd1);
            chk(inv_addr_o == exp_addr(full, base, k), full ? "R3 address" : "R4 address",
                64'(inv_addr_o), 64'(exp_addr(full, base, k)));
            if (poke) begin
                start_i = 1'($urandom);
                full_mode_i = 1'($urandom);
                start_addr_i = $urandom;
            end
        end
        @(negedge clk);
        start_i = 1'b0;
        if (full) done_m = 1'b1;
        chk(busy_o == 1'b0, "R5 busy falls", 64'(busy_o), 64'd0);
        chk(inv_strobe_o == 1'b0, "R10 strobe ends", 64'(inv_strobe_o), 64'd0);
        chk(cache_en_o == (done_m && sw_enable_i), full ? "R7 enable at end" : "R8 enable after single",
            64'(cache_en_o), 64'(done_m && sw_enable_i));
        @(negedge clk);
        chk(busy_o == 1'b0, "R6 no extra walk", 64'(busy_o), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        sw_enable_i = 1'b1;
        repeat (3) @(negedge clk);
        chk(busy_o == 1'b0, "R1 busy in reset", 64'(busy_o), 64'd0);
        chk(inv_strobe_o == 1'b0, "R1 strobe in reset", 64'(inv_strobe_o), 64'd0);
        chk(cache_en_o == 1'b0, "R1 enable in reset", 64'(cache_en_o), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o == 1'b0 && cache_en_o == 1'b0, "R1 after release", 64'({busy_o, cache_en_o}), 64'd0);
        chk(cache_en_o == 1'b0, "R9 sw enable before sweep", 64'(cache_en_o), 64'd0);

        // single-class clear must not enable the cache
        run_op(1'b0, 32'h0000_1237, 1'b0);
        chk(cache_en_o == 1'b0, "R8 still disabled", 64'(cache_en_o), 64'd0);

        // full walk from nonzero start address with restart attempts
        run_op(1'b1, 32'hABCD_0019, 1'b1);
        chk(cache_en_o == 1'b1, "R7 enabled after full walk", 64'(cache_en_o), 64'd1);

        @(negedge clk); sw_enable_i = 1'b0;
        @(negedge clk);
        chk(cache_en_o == 1'b0, "R7 gated by sw enable", 64'(cache_en_o), 64'd0);
        sw_enable_i = 1'b1;
        @(negedge clk);
        chk(cache_en_o == 1'b1, "R7 sticky done", 64'(cache_en_o), 64'd1);

        // random mix of modes
        for (int i = 0; i < 24; i++) begin
            sw_enable_i = 1'($urandom);
            run_op(($urandom % 4) == 0, $urandom, 1'($urandom));
        end

        // after a reset, a single clear alone must not enable
        rst_n = 1'b0; done_m = 1'b0; sw_enable_i = 1'b1;
        @(negedge clk);
        chk(cache_en_o == 1'b0, "R1 enable cleared by reset", 64'(cache_en_o), 64'd0);
        rst_n = 1'b1;
        run_op(1'b0, 32'h0000_03F0, 1'b1);
        chk(cache_en_o == 1'b0, "R9 no enable without full walk", 64'(cache_en_o), 64'd0);
        run_op(1'b1, 32'hFFFF_FFFF, 1'b0);
        chk(cache_en_o == 1'b1, "R7 enable after second walk", 64'(cache_en_o), 64'd1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule